// File: doc/BRIEF.md
# Dual Closest-Lower Presence Matcher

This unit serves one node of a multi-bit search tree whose nodes are presence vectors: bit `i` of the node is set when some stored key has the digit value `i` at that tree level. Given the node vector and a target digit, the unit reports two candidates in the same cycle. The primary candidate is the target digit itself when its bit is set. Otherwise it is the closest set digit below the target. The secondary candidate is the closest set digit strictly below the target. A tree controller uses it as the fallback branch when the subtree under the primary holds no usable key.

When a higher tree level has already matched a digit smaller than the one searched for, every key in the subtree is smaller than the search key. The lower levels then need the largest key in the subtree. The maximum mode serves this case. The primary becomes the most significant set bit of the node, the target is ignored, and the secondary becomes the next set bit below that primary.

The lower-bit search splits the node into fixed-size groups. Each group flags whether it holds any candidate and where its highest candidate sits. A select across the groups then combines the local positions into the final index. The results are registered, so the unit has one cycle of latency and accepts a new request every cycle.

Top module: `dual_match_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the registers clear: `rsp_valid`, `prim_hit` and `sec_hit` become 0, and `prim_idx` and `sec_idx` become 0.
- R2: `rsp_valid` is 1 in the cycle after a cycle with `req_valid` high, and 0 in the cycle after a cycle with `req_valid` low. Results appear on the same edge as `rsp_valid`.
- R3: In nearest mode (`max_mode` = 0), if bit `target` of `node_bits` is set, the result shows `prim_hit` = 1 and `prim_idx` = `target`.
- R4: In nearest mode, if bit `target` is clear, `prim_idx` is the highest set index below `target`, with `prim_hit` = 1.
- R5: In nearest mode, if no bit at or below `target` is set, `prim_hit` = 0 and `prim_idx` = 0.
- R6: In nearest mode, `sec_idx` is the highest set index strictly below `target`, with `sec_hit` = 1. If there is none, including whenever `target` is 0, `sec_hit` = 0 and `sec_idx` = 0. A secondary hit never occurs without a primary hit.
- R7: In maximum mode (`max_mode` = 1), `prim_idx` is the highest set index of the whole node and `target` has no effect. An all-zero node gives `prim_hit` = 0 and `prim_idx` = 0.
- R8: In maximum mode, `sec_idx` is the highest set index strictly below the primary result, and `sec_hit` = 0 with `sec_idx` = 0 when there is none.
- R9: A cycle with `req_valid` low leaves `prim_hit`, `prim_idx`, `sec_hit` and `sec_idx` unchanged on the next edge.
- R10: Requests issued on consecutive cycles each produce their own correct result one cycle later, with no idle cycles needed between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| node_bits | input | WIDTH (16) | Presence vector of the tree node |
| target | input | log2(WIDTH) (4) | Target digit |
| max_mode | input | 1 | 1 selects the maximum search and ignores `target` |
| rsp_valid | output | 1 | Results below belong to last cycle's request |
| prim_hit | output | 1 | A primary candidate exists |
| prim_idx | output | log2(WIDTH) (4) | Primary candidate index, 0 on a miss |
| sec_hit | output | 1 | A secondary candidate exists |
| sec_idx | output | log2(WIDTH) (4) | Secondary candidate index, 0 on a miss |

## Verification
The properties assume that `node_bits`, `target` and `max_mode` are stable and known across the clock edge that captures a request. They also assume that `target` is always a legal digit, which holds by its width when WIDTH is a power of two. The stimulus changes every input only on the falling clock edge. It draws targets from the full digit range and mixes dense, sparse and empty nodes, so that the exact-hit, fallback and miss cases each occur many times. Idle cycles are inserted between bursts of back-to-back requests to exercise the hold behaviour.

// File: rtl/dual_match_pkg.sv
package dual_match_pkg;

    // Search flavour applied to one node.
    typedef enum logic {
        MODE_NEAREST = 1'b0,
        MODE_MAX     = 1'b1
    } match_mode_e;

    localparam int DEFAULT_NODE_W = 16;
    localparam int DEFAULT_GROUP  = 4;

    // Highest set position inside one small group, 0 when empty.
    function automatic int unsigned group_high(input logic [31:0] v, input int unsigned n);
        int unsigned r;
        r = 0;
        for (int b = 0; b < 32; b++) begin
            if (b < n && v[b]) r = b;
        end
        return r;
    endfunction

endpackage

// File: rtl/dm_thermo_mask.sv
module dm_thermo_mask #(
    parameter int WIDTH = 16,
    localparam int IW = $clog2(WIDTH)
) (
    input  logic [IW-1:0]    pos,
    input  logic             incl,
    input  logic             all_ones,
    output logic [WIDTH-1:0] mask
);
    // Bit i is enabled when it lies below pos, or at pos when incl is set.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign mask[i] = all_ones | (IW'(i) < pos) | (incl & (IW'(i) == pos));
    end
endmodule

// File: rtl/dm_high_finder.sv
module dm_high_finder
    import dual_match_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int GROUP = 4,
    localparam int IW  = $clog2(WIDTH),
    localparam int NG  = WIDTH / GROUP,
    localparam int LW  = $clog2(GROUP),
    localparam int GSW = $clog2(NG)
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IW-1:0]    idx
);
    logic [NG-1:0]         grp_any;
    logic [NG-1:0][LW-1:0] grp_loc;
    logic [GSW-1:0]        sel;

    // Per-group look-ahead: any-flag and local highest position in parallel.
    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_any[g] = |vec[g*GROUP +: GROUP];
        assign grp_loc[g] = LW'(group_high(32'(vec[g*GROUP +: GROUP]), GROUP));
    end

    // Group select: the highest group holding a candidate wins.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < NG; k++) begin
            if (grp_any[k]) begin
                found = 1'b1;
                sel   = GSW'(k);
            end
        end
    end

    assign idx = {sel, grp_loc[sel]};
endmodule

// File: rtl/dual_match_unit.sv
module dual_match_unit
    import dual_match_pkg::*;
#(
    parameter int WIDTH = DEFAULT_NODE_W,
    parameter int GROUP = DEFAULT_GROUP,
    localparam int IW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [WIDTH-1:0] node_bits,
    input  logic [IW-1:0]    target,
    input  logic             max_mode,
    output logic             rsp_valid,
    output logic             prim_hit,
    output logic [IW-1:0]    prim_idx,
    output logic             sec_hit,
    output logic [IW-1:0]    sec_idx
);
    match_mode_e      mode;
    logic [WIDTH-1:0] p_mask, s_mask;
    logic [WIDTH-1:0] p_vec, s_vec;
    logic             p_found, s_found;
    logic [IW-1:0]    p_idx, s_idx, s_pos;

    assign mode = max_mode ? MODE_MAX : MODE_NEAREST;

    // Primary: at or below target, or the whole node in maximum mode.
    dm_thermo_mask #(.WIDTH(WIDTH)) u_pmask (
        .pos      (target),
        .incl     (1'b1),
        .all_ones (mode == MODE_MAX),
        .mask     (p_mask)
    );
    assign p_vec = node_bits & p_mask;

    dm_high_finder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_pfind (
        .vec   (p_vec),
        .found (p_found),
        .idx   (p_idx)
    );

    // Secondary: strictly below target, or strictly below the primary in maximum mode.
    assign s_pos = (mode == MODE_MAX) ? p_idx : target;

    dm_thermo_mask #(.WIDTH(WIDTH)) u_smask (
        .pos      (s_pos),
        .incl     (1'b0),
        .all_ones (1'b0),
        .mask     (s_mask)
    );
    assign s_vec = node_bits & s_mask;

    dm_high_finder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_sfind (
        .vec   (s_vec),
        .found (s_found),
        .idx   (s_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            prim_hit  <= 1'b0;
            prim_idx  <= '0;
            sec_hit   <= 1'b0;
            sec_idx   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                prim_hit <= p_found;
                prim_idx <= p_found ? p_idx : '0;
                sec_hit  <= s_found;
                sec_idx  <= s_found ? s_idx : '0;
            end
        end
    end

    // R2: one-cycle response flag
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r2_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R3: a set target bit is returned as the primary in nearest mode
    a_r3_exact: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !max_mode && node_bits[target]) |=> (prim_hit && prim_idx == $past(target)));

    // R5: an empty node never produces a hit
    a_r5_empty: assert property (@(posedge clk) disable iff (rst)
        (req_valid && node_bits == '0) |=> (!prim_hit && !sec_hit));

    // R6: secondary never exists without a primary, and never lies above it
    a_r6_order: assert property (@(posedge clk) disable iff (rst)
        sec_hit |-> (prim_hit && sec_idx <= prim_idx));

    // R7: maximum mode always hits on a non-empty node
    a_r7_max_hit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && max_mode && node_bits != '0) |=> prim_hit);

    // R8: in maximum mode the secondary lies strictly below the primary
    a_r8_strict: assert property (@(posedge clk) disable iff (rst)
        (req_valid && max_mode) |=> (!sec_hit || sec_idx < prim_idx));

    // R9: idle cycles hold the results
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(prim_idx) && $stable(sec_idx) && $stable(prim_hit) && $stable(sec_hit)));
endmodule

// File: tb/dual_match_unit_test.sv
module dual_match_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [W-1:0]  node_bits;
    logic [IW-1:0] target;
    logic          max_mode;
    logic          rsp_valid, prim_hit, sec_hit;
    logic [IW-1:0] prim_idx, sec_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_match_unit #(.WIDTH(W), .GROUP(4)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .node_bits(node_bits),
        .target(target), .max_mode(max_mode), .rsp_valid(rsp_valid),
        .prim_hit(prim_hit), .prim_idx(prim_idx), .sec_hit(sec_hit), .sec_idx(sec_idx)
    );

    function automatic int ref_prim(logic [W-1:0] b, int t, bit m);
        int r = -1;
        for (int i = 0; i < W; i++) if (b[i] && (m || i <= t)) r = i;
        return r;
    endfunction

    function automatic int ref_sec(logic [W-1:0] b, int t, bit m);
        int lim = m ? ref_prim(b, t, m) : t;
        int r = -1;
        for (int i = 0; i < W; i++) if (b[i] && i < lim) r = i;
        return r;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive on the falling edge, sample the result on the next falling edge.
    task automatic send(logic [W-1:0] b, int t, bit m, string tag);
        int ep, es;
        req_valid = 1'b1;
        node_bits = b;
        target    = IW'(t);
        max_mode  = m;
        ep = ref_prim(b, t, m);
        es = ref_sec(b, t, m);
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R2 rsp_valid", int'(rsp_valid), 1);
        chk(prim_hit == (ep >= 0), {tag, " prim_hit"}, int'(prim_hit), int'(ep >= 0));
        chk(int'(prim_idx) == (ep < 0 ? 0 : ep), {tag, " prim_idx"}, int'(prim_idx), ep < 0 ? 0 : ep);
        chk(sec_hit == (es >= 0), {tag, " sec_hit"}, int'(sec_hit), int'(es >= 0));
        chk(int'(sec_idx) == (es < 0 ? 0 : es), {tag, " sec_idx"}, int'(sec_idx), es < 0 ? 0 : es);
    endtask

    task automatic idle_cycle();
        logic [IW-1:0] pi, si;
        logic ph, sh;
        pi = prim_idx; si = sec_idx; ph = prim_hit; sh = sec_hit;
        req_valid = 1'b0;
        node_bits = 16'hFFFF ^ node_bits;
        target    = ~target;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 rsp_valid", int'(rsp_valid), 0);
        chk(prim_idx == pi && prim_hit == ph, "R9 prim hold", int'(prim_idx), int'(pi));
        chk(sec_idx == si && sec_hit == sh, "R9 sec hold", int'(sec_idx), int'(si));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; req_valid = 1'b1; node_bits = 16'hFFFF; target = 4'd9; max_mode = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset clears everything even with a request present
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(prim_hit == 1'b0 && prim_idx == '0, "R1 primary", int'(prim_idx), 0);
        chk(sec_hit == 1'b0 && sec_idx == '0, "R1 secondary", int'(sec_idx), 0);
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);

        send(16'h0080, 7, 1'b0, "R3");
        send(16'h0081, 7, 1'b0, "R3");
        send(16'h8000, 15, 1'b0, "R3");
        send(16'h0050, 7, 1'b0, "R4");
        send(16'h0003, 14, 1'b0, "R4");
        send(16'hFF00, 7, 1'b0, "R5");
        send(16'h0000, 15, 1'b0, "R5");
        send(16'h0001, 0, 1'b0, "R6");
        send(16'hFFFF, 0, 1'b0, "R6");
        send(16'h8421, 3, 1'b1, "R7");
        send(16'h8421, 0, 1'b1, "R7");
        send(16'h0000, 5, 1'b1, "R7");
        send(16'h0001, 9, 1'b1, "R8");
        send(16'hC000, 2, 1'b1, "R8");
        idle_cycle();
        idle_cycle();

        for (int n = 0; n < 6000; n++) begin
            logic [W-1:0] b;
            int sel = $urandom_range(0, 3);
            b = W'($urandom);
            if (sel == 1) b = b & W'($urandom) & W'($urandom);
            if (sel == 2) b = W'(1) << $urandom_range(0, W-1);
            if (sel == 3 && $urandom_range(0, 7) == 0) b = '0;
            send(b, $urandom_range(0, W-1), bit'($urandom_range(0, 1)), "R10");
            if (n % 37 == 36) idle_cycle();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule